// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. It receives an asynchronous input pin and synchronizes it into the timer clock domain with two flip-flops. A digital filter with a programmable strength then removes short glitches, and an edge detector turns the cleaned level into event pulses. The active edge can be rising, falling or both.

A source selector decides which event drives the channel. The choices are this channel's own edges, the edges of the paired neighbouring channel's filtered level, or an internal trigger pulse. A selector value of zero takes the channel out of input mode. An event prescaler passes one event in 1, 2, 4 or 8. Each event that passes copies the free-running counter value, which arrives as an input, into the capture register and sets the capture flag.

A second capture while that flag is still set also raises an over-capture flag. The interrupt output is the flag gated by an enable. While the channel is in input mode, software writes to the capture register have no effect.

Top module: `cap_channel`

## Requirements
- R1: During and after asynchronous reset, `cap_val_o`, `cap_flag_o`, `ovr_flag_o`, `irq_o` and `filt_o` are all 0.
- R2: The input passes two synchronizer flops. With `flt_cfg_i` = 0, a level change on `ch_in_i` driven between clock edges appears on `filt_o` after the third rising edge.
- R3: With `flt_cfg_i` = N > 0, `filt_o` takes a new level only after the synchronized input has held that level for 2*N consecutive clocks. A shorter pulse is removed.
- R4: Edge selection uses `edge_both_i`=1 for both edges. With `edge_both_i`=0, `edge_inv_i`=0 selects the rising edge and `edge_inv_i`=1 selects the falling edge. The edge detector compares the filtered level with its value one clock earlier.
- R5: `src_sel_i` selects the event source: 1 selects own filtered edges, 2 selects edges of `nbr_filt_i` (under the same polarity rule), and 3 treats every cycle with `trig_i` high as an event. With 0 the channel never captures.
- R6: On an effective capture at a clock edge, `cap_val_o` takes the `cnt_i` value present at that edge and `cap_flag_o` goes to 1.
- R7: `irq_o` is 1 exactly when `cap_flag_o` is 1 and `int_en_i` is 1.
- R8: A capture while `cap_flag_o` is already 1 sets `ovr_flag_o`.
- R9: A `flag_clr_i` pulse clears both flags. A capture in the same cycle wins: the capture flag stays set, and the over-capture flag is set if the capture flag was already set.
- R10: `psc_cfg_i` = 0, 1, 2, 3 captures on every 1st, 2nd, 4th or 8th selected event respectively.
- R11: The prescaler count restarts from zero when `cap_en_i` is 0 or in the cycle `psc_cfg_i` changes. An event in that cycle is dropped.
- R12: A `sw_wr_i` pulse loads `sw_wdata_i` into `cap_val_o` on the next edge only while `src_sel_i` is 0. Otherwise the write is ignored.
- R13: With `cap_en_i` = 0, no capture occurs and `cap_val_o` and `cap_flag_o` are not changed by events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ch_in_i | input | 1 | Asynchronous channel input pin |
| nbr_filt_i | input | 1 | Filtered level of paired channel, timer domain |
| trig_i | input | 1 | Internal trigger pulse, timer domain |
| cnt_i | input | CNT_W | Free-running counter value |
| flt_cfg_i | input | FLT_W | Filter strength, 0 disables |
| edge_inv_i | input | 1 | Falling edge when not both |
| edge_both_i | input | 1 | Both edges active |
| src_sel_i | input | 2 | Capture source, 0 = not input mode |
| psc_cfg_i | input | PSC_W | Event prescaler, divide by 2^value |
| cap_en_i | input | 1 | Capture enable |
| int_en_i | input | 1 | Interrupt enable |
| sw_wr_i | input | 1 | Software write strobe to capture register |
| sw_wdata_i | input | CNT_W | Software write data |
| flag_clr_i | input | 1 | Clear pulse for both flags |
| cap_val_o | output | CNT_W | Capture register |
| cap_flag_o | output | 1 | Capture flag |
| ovr_flag_o | output | 1 | Over-capture flag |
| irq_o | output | 1 | Gated interrupt |
| filt_o | output | 1 | Filtered level, for the paired channel |

## Verification
The assertions assume that `nbr_filt_i`, `trig_i` and all configuration inputs are synchronous to `clk_i`; only `ch_in_i` may change at any time. They also assume that `src_sel_i` is read in the same cycle as a write or clear strobe. The stimulus changes every input shortly after a falling edge, so each value is stable over the following rising edge. `flt_cfg_i` is changed only while the synchronized input matches the filtered level, so no half-counted run is carried across a strength change.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_OWN = 2'd1,
    SRC_NBR = 2'd2,
    SRC_TRG = 2'd3
  } cap_src_e;

  function automatic logic pick_edge(input logic rise, input logic fall,
                                     input logic inv, input logic both);
    if (both) return rise | fall;
    return inv ? fall : rise;
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
  parameter int FLT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic [FLT_W-1:0] cfg_i,
  output logic             q_o
);
  localparam int RUN_W = FLT_W + 2;

  logic             lvl_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] lim;

  // switch on the 2N-th consecutive differing sample
  assign lim = RUN_W'({cfg_i, 1'b0}) - RUN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (cfg_i == '0) begin
      lvl_q <= d_i;
      run_q <= '0;
    end else if (d_i == lvl_q) begin
      run_q <= '0;
    end else if (run_q >= lim) begin
      lvl_q <= d_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + RUN_W'(1);
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/cap_edge.sv
module cap_edge
  import cap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic inv_i,
  input  logic both_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign evt_o = pick_edge(lvl_i & ~prev_q, ~lvl_i & prev_q, inv_i, both_i);
endmodule

// File: rtl/cap_presc.sv
module cap_presc #(
  parameter int PSC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             evt_i,
  input  logic [PSC_W-1:0] cfg_i,
  output logic             fire_o
);
  localparam int CW = (1 << PSC_W) - 1;

  logic [CW-1:0]    cnt_q;
  logic [PSC_W-1:0] cfg_q;
  logic             restart;
  logic [CW-1:0]    last;

  assign restart = !en_i || (cfg_i != cfg_q);
  assign last    = CW'((1 << cfg_i) - 1);
  assign fire_o  = !restart && evt_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_i;
      if (restart || fire_o) cnt_q <= '0;
      else if (evt_i)        cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FLT_W = 4,
  parameter int PSC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ch_in_i,
  input  logic             nbr_filt_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [FLT_W-1:0] flt_cfg_i,
  input  logic             edge_inv_i,
  input  logic             edge_both_i,
  input  logic [1:0]       src_sel_i,
  input  logic [PSC_W-1:0] psc_cfg_i,
  input  logic             cap_en_i,
  input  logic             int_en_i,
  input  logic             sw_wr_i,
  input  logic [CNT_W-1:0] sw_wdata_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             ovr_flag_o,
  output logic             irq_o,
  output logic             filt_o
);
  localparam int SYNC_STAGES = 2;

  cap_src_e         src;
  logic             sync_lvl;
  logic             own_lvl;
  logic             own_evt;
  logic             nbr_evt;
  logic             sel_evt;
  logic             fire;
  logic [CNT_W-1:0] val_q;
  logic             flag_q;
  logic             ovr_q;

  assign src = cap_src_e'(src_sel_i);

  cap_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ch_in_i), .q_o(sync_lvl)
  );

  cap_filter #(.FLT_W(FLT_W)) i_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_lvl), .cfg_i(flt_cfg_i), .q_o(own_lvl)
  );

  cap_edge i_edge_own (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(own_lvl),
    .inv_i(edge_inv_i), .both_i(edge_both_i), .evt_o(own_evt)
  );

  cap_edge i_edge_nbr (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(nbr_filt_i),
    .inv_i(edge_inv_i), .both_i(edge_both_i), .evt_o(nbr_evt)
  );

  always_comb begin
    unique case (src)
      SRC_OWN: sel_evt = own_evt;
      SRC_NBR: sel_evt = nbr_evt;
      SRC_TRG: sel_evt = trig_i;
      default: sel_evt = 1'b0;
    endcase
  end

  cap_presc #(.PSC_W(PSC_W)) i_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cap_en_i),
    .evt_i(sel_evt), .cfg_i(psc_cfg_i), .fire_o(fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (fire)                           val_q <= cnt_i;
      else if (sw_wr_i && src == SRC_OFF) val_q <= sw_wdata_i;
      // capture outranks clear
      flag_q <= fire | (flag_q & ~flag_clr_i);
      ovr_q  <= (fire & flag_q) | (ovr_q & ~flag_clr_i);
    end
  end

  assign cap_val_o  = val_q;
  assign cap_flag_o = flag_q;
  assign ovr_flag_o = ovr_q;
  assign irq_o      = flag_q & int_en_i;
  assign filt_o     = own_lvl;
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       src_sel_i,
  input logic             cap_en_i,
  input logic             int_en_i,
  input logic             sw_wr_i,
  input logic [CNT_W-1:0] sw_wdata_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_flag_o,
  input logic             ovr_flag_o,
  input logic             irq_o
);
  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> !cap_flag_o && !ovr_flag_o && !irq_o);

  p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |-> int_en_i && cap_flag_o);

  p_ovr_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_flag_o) |-> $past(cap_flag_o));

  p_flag_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_flag_o) |-> $past(cap_en_i) && ($past(src_sel_i) != 2'd0));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !cap_en_i) |=> !cap_flag_o && !ovr_flag_o);

  p_sw_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'd0 && sw_wr_i) |=> cap_val_o == $past(sw_wdata_i));

  p_no_cap_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i != 2'd0 && !cap_en_i) |=> $stable(cap_val_o));
endmodule

bind cap_channel cap_channel_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_sel_i(src_sel_i), .cap_en_i(cap_en_i),
  .int_en_i(int_en_i), .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i),
  .flag_clr_i(flag_clr_i), .cap_val_o(cap_val_o), .cap_flag_o(cap_flag_o),
  .ovr_flag_o(ovr_flag_o), .irq_o(irq_o)
);

// File: tb/test_cap_channel.sv
module test_cap_channel;
  localparam int CLK_T = 10;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ch_in = 0, nbr = 0, trig = 0, inv = 0, both = 0, cap_en = 0, int_en = 0;
  logic sw_wr = 0, clr = 0;
  logic [CW-1:0] cnt = 0, wdata = 0;
  logic [3:0] flt = 0;
  logic [1:0] src = 0, psc = 0;
  logic [CW-1:0] cap_val;
  logic cap_flag, ovr_flag, irq, filt;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  cap_channel i_cap_channel (
    .clk_i(clk), .rst_ni(rst_n), .ch_in_i(ch_in), .nbr_filt_i(nbr), .trig_i(trig),
    .cnt_i(cnt), .flt_cfg_i(flt), .edge_inv_i(inv), .edge_both_i(both),
    .src_sel_i(src), .psc_cfg_i(psc), .cap_en_i(cap_en), .int_en_i(int_en),
    .sw_wr_i(sw_wr), .sw_wdata_i(wdata), .flag_clr_i(clr),
    .cap_val_o(cap_val), .cap_flag_o(cap_flag), .ovr_flag_o(ovr_flag),
    .irq_o(irq), .filt_o(filt)
  );

  // behavioural reference
  bit m_s[$];
  bit m_f, m_fp, m_np, m_flag, m_ovr;
  int m_run, m_pc, m_pcfg;
  logic [CW-1:0] m_val;

  function automatic bit sel(bit r, bit f);
    if (both) return r | f;
    return inv ? f : r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s = '{0, 0}; m_f = 0; m_fp = 0; m_np = 0; m_flag = 0; m_ovr = 0;
      m_run = 0; m_pc = 0; m_pcfg = 0; m_val = 0;
    end else begin
      bit ev, fire, s;
      ev = 0; fire = 0;
      case (src)
        2'd1: ev = sel(m_f && !m_fp, !m_f && m_fp);
        2'd2: ev = sel(nbr && !m_np, !nbr && m_np);
        2'd3: ev = trig;
        default: ev = 0;
      endcase
      if (!cap_en || int'(psc) != m_pcfg) m_pc = 0;
      else if (ev) begin
        if (m_pc == (1 << psc) - 1) begin fire = 1; m_pc = 0; end
        else m_pc++;
      end
      m_pcfg = int'(psc);
      m_ovr = (fire && m_flag) || (m_ovr && !clr);
      m_flag = fire || (m_flag && !clr);
      if (fire) m_val = cnt;
      else if (src == 0 && sw_wr) m_val = wdata;
      m_fp = m_f; m_np = nbr;
      s = m_s.pop_front();
      if (flt == 0) begin m_f = s; m_run = 0; end
      else if (s != m_f) begin
        m_run++;
        if (m_run >= 2 * flt) begin m_f = s; m_run = 0; end
      end else m_run = 0;
      m_s.push_back(ch_in);
    end
  end

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 cap_val", cap_val, m_val);
      chk("R6 cap_flag", CW'(cap_flag), CW'(m_flag));
      chk("R8 ovr_flag", CW'(ovr_flag), CW'(m_ovr));
      chk("R7 irq", CW'(irq), CW'(m_flag && int_en));
      chk("R3 filt", CW'(filt), CW'(m_f));
    end
    cnt <= cnt + 16'd7;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_clr();
    clr = 1; step(1); clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(2);
    // R1 reset state
    chk("R1 val", cap_val, 0);
    chk("R1 flags", CW'({cap_flag, ovr_flag, irq, filt}), 0);
    rst_n = 1; step(1);

    // R2 latency: change to filt_o after the third rising edge
    ch_in = 1; step(2); chk("R2 early", CW'(filt), 0);
    step(1); chk("R2 arrive", CW'(filt), 1);
    ch_in = 0; step(4);

    // R6 R7 own rising edges, every event
    src = 1; cap_en = 1; int_en = 1;
    for (int i = 0; i < 4; i++) begin
      ch_in = 1; step(3 + i); ch_in = 0; step(4); pulse_clr();
    end
    // R8 over-capture then R9 clear
    ch_in = 1; step(4); ch_in = 0; step(4); ch_in = 1; step(4);
    chk("R8 ovr", CW'(ovr_flag), 1);
    pulse_clr(); chk("R9 cleared", CW'({cap_flag, ovr_flag}), 0);
    ch_in = 0; step(4);
    int_en = 0; ch_in = 1; step(5); chk("R7 gated", CW'(irq), 0);
    ch_in = 0; step(4); int_en = 1; pulse_clr();

    // R4 falling and both edges
    inv = 1;
    repeat (3) begin ch_in = 1; step(4); ch_in = 0; step(5); pulse_clr(); end
    both = 1;
    repeat (3) begin ch_in = ~ch_in; step(5); pulse_clr(); end
    both = 0; inv = 0; ch_in = 0; step(5); pulse_clr();

    // R3 filter strength 3: 6 stable clocks
    flt = 3; step(2);
    ch_in = 1; step(4); ch_in = 0; step(8);
    chk("R3 glitch removed", CW'(filt), 0);
    ch_in = 1; step(5); ch_in = 0; step(1); ch_in = 1; step(12);
    chk("R3 passed", CW'(filt), 1);
    ch_in = 0; step(12); flt = 0; step(3); pulse_clr();

    // R5 neighbour and trigger sources; R10 prescaler
    src = 2;
    for (int k = 0; k < 6; k++) begin nbr = ~nbr; step(2 + k % 3); end
    nbr = 0; step(2); pulse_clr();
    src = 3;
    for (int p = 0; p < 4; p++) begin
      psc = 2'(p); step(2); pulse_clr();
      for (int e = 0; e < 10; e++) begin trig = 1; step(1); trig = 0; step(1 + e % 2); end
      pulse_clr();
    end
    // R11 restart on prescaler change and on disable
    psc = 2; repeat (3) begin trig = 1; step(1); trig = 0; step(1); end
    psc = 1; trig = 1; step(1); trig = 0; step(1);
    repeat (3) begin trig = 1; step(1); trig = 0; step(1); end
    cap_en = 0; step(1); cap_en = 1;
    repeat (4) begin trig = 1; step(1); trig = 0; step(1); end
    // R13 disabled channel ignores events
    cap_en = 0; pulse_clr();
    repeat (5) begin trig = 1; step(1); trig = 0; step(1); end
    chk("R13 no flag", CW'(cap_flag), 0);
    cap_en = 1; psc = 0;

    // R12 write lock in input mode, load in output mode
    wdata = 16'hBEEF; sw_wr = 1; step(1); sw_wr = 0;
    chk("R12 locked", CW'(cap_val == 16'hBEEF), 0);
    src = 0; wdata = 16'h1234; sw_wr = 1; step(1); sw_wr = 0;
    chk("R12 loaded", cap_val, 16'h1234);
    // R5 off mode: edges and triggers do nothing
    pulse_clr();
    trig = 1; ch_in = 1; step(5); trig = 0; ch_in = 0; step(5);
    chk("R5 off", CW'(cap_flag), 0);

    // R9 capture in same cycle as clear: capture wins
    src = 3; trig = 1; step(1); trig = 0; step(1);
    trig = 1; clr = 1; step(1); trig = 0; clr = 0;
    chk("R9 capture wins", CW'({cap_flag, ovr_flag}), 3);
    step(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule